// File: doc/BRIEF.md
# Flash Status Register Write Sequencer

This block sits on the host side of a single-lane SPI link to a serial flash. It updates one of the flash's three status registers. A user request carries a register index, a data byte and a persistence choice. The block turns that request into up to three chip-select frames:

1. An enable frame.
2. The register write frame.
3. For a persistent write only, a busy-poll frame. In this frame the status byte streams back repeatedly until the device reports idle.

On completion the block pulses `done` and, if needed, flags a timeout.

The SPI clock is derived from the system clock by a parameter, so the link runs at a fixed fraction of the system rate. Between frames, chip select is held high for a configurable minimum number of system cycles. The user side is a simple start/ready handshake. The request fields are captured in the cycle that start is accepted.

Top module: `sreg_write_seq`

## Requirements
- R1: With `volatile_mode`=0 the first frame carries exactly one byte, 8'h06. With `volatile_mode`=1 it carries exactly one byte, 8'h50.
- R2: The second frame carries exactly two bytes. The first is the write opcode: 8'h01, 8'h31 or 8'h11 for `reg_sel` 1, 2 or 3. The second is the `wr_data` captured at start.
- R3: Each byte is sent most significant bit first. `spi_sck` idles low whenever `spi_cs_n` is high. Each SCK level lasts `CLK_DIV` system cycles. Within a frame, `spi_mosi` changes only on a falling SCK edge.
- R4: `spi_miso` is sampled at the rising SCK edge. The last bit of a status byte (bit 0, the busy flag) decides whether polling continues.
- R5: A persistent write adds a third frame. It begins with a single 8'h05, followed by zero bytes on MOSI while status bytes stream in. Chip select rises right after the first status byte whose bit 0 is 0. All other status bits are ignored.
- R6: If `POLL_LIMIT` consecutive status bytes all report busy, chip select rises after the last one, and `err` is 1 in the cycle `done` pulses. Otherwise `err` is 0 at done.
- R7: A volatile write issues only the first two frames and never polls.
- R8: Between any two frames, `spi_cs_n` stays high for at least `CS_GAP` system cycles.
- R9: `ready` is high only when idle. It drops the cycle after a start is accepted, stays low until `done` has pulsed for exactly one cycle, and then returns high. `spi_cs_n` is high whenever `ready` is high.
- R10: A start while not ready is ignored. A start with `reg_sel`=0 is also ignored: no frame is issued and `ready` stays high.
- R11: After reset, `spi_cs_n`=1, `spi_sck`=0, `spi_mosi`=0, `ready`=1, `done`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, accepted while ready |
| reg_sel | input | 2 | Target status register index, 1 to 3 |
| wr_data | input | 8 | Byte to write into the register |
| volatile_mode | input | 1 | 1 = volatile write, 0 = persistent write |
| ready | output | 1 | Idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Poll timeout flag, valid from done until next start |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
Two events can fall on the same status byte: reaching the poll budget and seeing the busy flag clear. When busy stays set for exactly `POLL_LIMIT`-1 bytes, the byte that exhausts the budget is also the first idle one. The bench's flash model is swept over busy lengths on both sides of that point, and on that point itself. The expected frame length, min(busy+1, `POLL_LIMIT`)+1 bytes, and the expected error, busy >= `POLL_LIMIT`, are computed arithmetically. When the two events coincide, success must win.

// File: rtl/sreg_seq_pkg.sv
package sreg_seq_pkg;

   localparam int BYTE_W = 8;

   localparam logic [BYTE_W-1:0] OPC_WR_ENABLE     = 8'h06;
   localparam logic [BYTE_W-1:0] OPC_WR_ENABLE_VOL = 8'h50;
   localparam logic [BYTE_W-1:0] OPC_STATUS1_RD    = 8'h05;
   localparam logic [BYTE_W-1:0] OPC_FILL          = 8'h00;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ENABLE,
      ST_WR_OPC,
      ST_WR_DAT,
      ST_POLL_OPC,
      ST_POLL_RD,
      ST_GAP,
      ST_FINISH
   } seq_state_t;

   function automatic logic [BYTE_W-1:0] write_opcode(input logic [1:0] idx);
      case (idx)
         2'd2:    write_opcode = 8'h31;
         2'd3:    write_opcode = 8'h11;
         default: write_opcode = 8'h01;
      endcase
   endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
   parameter int HALF_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] tx_byte,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       byte_done,
   output logic       rx_last_bit
);

   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_byte_engine: HALF_DIV must be at least 1");
      end
   endgenerate

   logic [7:0]    shreg_q;
   logic [2:0]    bit_q;
   logic [CW-1:0] hcnt_q;
   logic          sck_q;
   logic          run_q;
   logic          samp_q;
   logic          tick;

   assign tick      = run_q && (hcnt_q == HALF_LAST);
   assign byte_done = tick && sck_q && (bit_q == 3'd7);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         bit_q   <= '0;
         hcnt_q  <= '0;
         sck_q   <= 1'b0;
         run_q   <= 1'b0;
         samp_q  <= 1'b0;
      end else if (load) begin
         shreg_q <= tx_byte;
         bit_q   <= '0;
         hcnt_q  <= '0;
         sck_q   <= 1'b0;
         run_q   <= 1'b1;
      end else if (run_q) begin
         hcnt_q <= tick ? '0 : hcnt_q + CW'(1);
         if (tick) begin
            sck_q <= ~sck_q;
            if (!sck_q) begin
               samp_q <= miso;
            end else if (bit_q == 3'd7) begin
               run_q <= 1'b0;
            end else begin
               shreg_q <= {shreg_q[6:0], 1'b0};
               bit_q   <= bit_q + 3'd1;
            end
         end
      end
   end

   assign sck         = sck_q;
   assign mosi        = run_q & shreg_q[7];
   assign rx_last_bit = samp_q;

endmodule

// File: rtl/cycle_budget.sv
module cycle_budget #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic step,
   output logic last
);

   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] FINAL = CW'(LIMIT - 1);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("cycle_budget: LIMIT must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   assign last = step && (cnt_q == FINAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= last ? '0 : cnt_q + CW'(1);
      end
   end

endmodule

// File: rtl/sreg_write_seq.sv
module sreg_write_seq
   import sreg_seq_pkg::*;
#(
   parameter int CLK_DIV    = 4,
   parameter int CS_GAP     = 8,
   parameter int POLL_LIMIT = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [1:0] reg_sel,
   input  logic [7:0] wr_data,
   input  logic       volatile_mode,
   output logic       ready,
   output logic       done,
   output logic       err,
   output logic       spi_cs_n,
   output logic       spi_sck,
   output logic       spi_mosi,
   input  logic       spi_miso
);

   generate
      if (CS_GAP < 1) begin : g_bad_gap
         $error("sreg_write_seq: CS_GAP must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_poll
         $error("sreg_write_seq: POLL_LIMIT must be at least 1");
      end
   endgenerate

   seq_state_t  state_q, after_q;
   logic [1:0]  idx_q;
   logic [7:0]  dat_q;
   logic        vol_q;
   logic        err_pend_q;
   logic        err_q;
   logic        cs_n_q;

   logic        accept;
   logic        eng_load;
   logic [7:0]  eng_tx;
   logic        byte_done;
   logic        busy_bit;
   logic        gap_last;
   logic        poll_last;
   logic        poll_step;

   assign accept    = (state_q == ST_IDLE) && start && (reg_sel != 2'd0);
   assign poll_step = (state_q == ST_POLL_RD) && byte_done && busy_bit;

   spi_byte_engine #(.HALF_DIV(CLK_DIV)) u_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (eng_load),
      .tx_byte     (eng_tx),
      .miso        (spi_miso),
      .sck         (spi_sck),
      .mosi        (spi_mosi),
      .byte_done   (byte_done),
      .rx_last_bit (busy_bit)
   );

   cycle_budget #(.LIMIT(CS_GAP)) u_gap (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q != ST_GAP),
      .step  (state_q == ST_GAP),
      .last  (gap_last)
   );

   cycle_budget #(.LIMIT(POLL_LIMIT)) u_poll (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (state_q == ST_POLL_OPC),
      .step  (poll_step),
      .last  (poll_last)
   );

   always_comb begin
      eng_load = 1'b0;
      eng_tx   = OPC_FILL;
      case (state_q)
         ST_IDLE: begin
            if (accept) begin
               eng_load = 1'b1;
               eng_tx   = volatile_mode ? OPC_WR_ENABLE_VOL : OPC_WR_ENABLE;
            end
         end
         ST_GAP: begin
            if (gap_last && (after_q != ST_FINISH)) begin
               eng_load = 1'b1;
               eng_tx   = (after_q == ST_WR_OPC) ? write_opcode(idx_q) : OPC_STATUS1_RD;
            end
         end
         ST_WR_OPC: begin
            if (byte_done) begin
               eng_load = 1'b1;
               eng_tx   = dat_q;
            end
         end
         ST_POLL_OPC: begin
            eng_load = byte_done;
         end
         ST_POLL_RD: begin
            eng_load = byte_done && busy_bit && !poll_last;
         end
         default: begin
            eng_load = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         after_q    <= ST_IDLE;
         idx_q      <= 2'd1;
         dat_q      <= '0;
         vol_q      <= 1'b0;
         err_pend_q <= 1'b0;
         err_q      <= 1'b0;
         cs_n_q     <= 1'b1;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q    <= ST_ENABLE;
                  idx_q      <= reg_sel;
                  dat_q      <= wr_data;
                  vol_q      <= volatile_mode;
                  err_q      <= 1'b0;
                  err_pend_q <= 1'b0;
                  cs_n_q     <= 1'b0;
               end
            end
            ST_ENABLE: begin
               if (byte_done) begin
                  cs_n_q  <= 1'b1;
                  state_q <= ST_GAP;
                  after_q <= ST_WR_OPC;
               end
            end
            ST_GAP: begin
               if (gap_last) begin
                  if (after_q == ST_FINISH) begin
                     state_q <= ST_FINISH;
                     err_q   <= err_pend_q;
                  end else begin
                     state_q <= after_q;
                     cs_n_q  <= 1'b0;
                  end
               end
            end
            ST_WR_OPC: begin
               if (byte_done) begin
                  state_q <= ST_WR_DAT;
               end
            end
            ST_WR_DAT: begin
               if (byte_done) begin
                  cs_n_q  <= 1'b1;
                  state_q <= ST_GAP;
                  after_q <= vol_q ? ST_FINISH : ST_POLL_OPC;
               end
            end
            ST_POLL_OPC: begin
               if (byte_done) begin
                  state_q <= ST_POLL_RD;
               end
            end
            ST_POLL_RD: begin
               if (byte_done && (!busy_bit || poll_last)) begin
                  cs_n_q     <= 1'b1;
                  state_q    <= ST_GAP;
                  after_q    <= ST_FINISH;
                  err_pend_q <= busy_bit;
               end
            end
            ST_FINISH: begin
               state_q <= ST_IDLE;
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign ready    = (state_q == ST_IDLE);
   assign done     = (state_q == ST_FINISH);
   assign err      = err_q;
   assign spi_cs_n = cs_n_q;

endmodule

// File: rtl/sreg_seq_chk.sv
module sreg_seq_chk #(
   parameter int CS_GAP = 8
) (
   input logic clk,
   input logic rst_n,
   input logic ready,
   input logic done,
   input logic err,
   input logic spi_cs_n,
   input logic spi_sck,
   input logic spi_mosi
);

   localparam int HW = $clog2(CS_GAP + 2);
   localparam logic [HW-1:0] HI_SAT = HW'(CS_GAP);

   logic [HW-1:0] hi_cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt_q <= HI_SAT;
      end else if (!spi_cs_n) begin
         hi_cnt_q <= '0;
      end else if (hi_cnt_q != HI_SAT) begin
         hi_cnt_q <= hi_cnt_q + HW'(1);
      end
   end

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck); // R3

   AST_MOSI_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (!spi_cs_n && !$past(spi_cs_n) && !$fell(spi_sck)) |-> $stable(spi_mosi)); // R3

   AST_CS_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> (hi_cnt_q >= HI_SAT)); // R8

   AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> spi_cs_n); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && ready)); // R9

   AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done); // R6

   AST_ERR_CLEARS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err) |-> !ready); // R6

endmodule

bind sreg_write_seq sreg_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ready    (ready),
   .done     (done),
   .err      (err),
   .spi_cs_n (spi_cs_n),
   .spi_sck  (spi_sck),
   .spi_mosi (spi_mosi)
);

// File: tb/sreg_write_seq_tb.sv
module sreg_write_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int P_DIV      = 2;
   localparam int P_GAP      = 3;
   localparam int P_LIMIT    = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [1:0] reg_sel = 2'd1;
   logic [7:0] wr_data = 8'h00;
   logic       volatile_mode = 1'b0;
   logic       ready, done, err;
   logic       spi_cs_n, spi_sck, spi_mosi;
   logic       spi_miso = 1'b0;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sreg_write_seq #(.CLK_DIV(P_DIV), .CS_GAP(P_GAP), .POLL_LIMIT(P_LIMIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .reg_sel(reg_sel), .wr_data(wr_data),
      .volatile_mode(volatile_mode), .ready(ready), .done(done), .err(err),
      .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ---------------- flash model ----------------
   logic [7:0] fb [8][16];
   int  fbits [8];
   int  n_frames = 0;
   int  bitcnt   = 0;
   logic [7:0] cur = 8'h00;
   int  busy_n   = 0;
   bit  armed    = 1'b0;
   int  last_hi  = -1;
   int  gap_bad  = 0;
   int  sck_bad  = 0;
   int  last_edge = 0;
   int  k_idx, b_idx;
   logic [7:0] sbyte;

   always @(posedge clk) cyc++;

   always @(negedge spi_cs_n) if (armed) begin
      bitcnt = 0;
      if (last_hi >= 0 && (cyc - last_hi) < P_GAP) gap_bad++;
      last_edge = cyc;
   end

   always @(posedge spi_cs_n) if (armed && n_frames < 8) begin
      fbits[n_frames] = bitcnt;
      n_frames++;
      last_hi = cyc;
   end

   always @(posedge spi_sck) if (armed && !spi_cs_n) begin
      if ((cyc - last_edge) != P_DIV) sck_bad++;
      last_edge = cyc;
      cur = {cur[6:0], spi_mosi};
      bitcnt++;
      if ((bitcnt % 8) == 0 && n_frames < 8 && (bitcnt / 8) <= 16)
         fb[n_frames][bitcnt/8 - 1] = cur;
   end

   always @(negedge spi_sck) if (armed) begin
      if ((cyc - last_edge) != P_DIV) sck_bad++;
      last_edge = cyc;
      if (!spi_cs_n && n_frames < 8 && bitcnt >= 8 && fb[n_frames][0] == 8'h05) begin
         k_idx = (bitcnt - 8) / 8;
         b_idx = 7 - ((bitcnt - 8) % 8);
         sbyte = (k_idx < busy_n) ? 8'h81 : 8'h80;
         spi_miso = sbyte[b_idx];
      end
   end

   task automatic clear_log();
      n_frames = 0;
      gap_bad  = 0;
      sck_bad  = 0;
      for (int f = 0; f < 8; f++) begin
         fbits[f] = 0;
         for (int b = 0; b < 16; b++) fb[f][b] = 8'h00;
      end
   endtask

   function automatic logic [7:0] exp_opc(input int idx);
      return (idx == 2) ? 8'h31 : (idx == 3) ? 8'h11 : 8'h01;
   endfunction

   task automatic run_op(input int idx, input logic [7:0] data, input bit vol,
                         input int busy, input bit poke);
      int  waited;
      int  nb;
      bit  got;
      bit  fill_ok;
      clear_log();
      busy_n = busy;
      @(negedge clk);
      reg_sel = 2'(idx); wr_data = data; volatile_mode = vol; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(ready == 1'b0, "R9 ready low after accept", ready, 0);
      reg_sel = 2'd3; wr_data = ~data; volatile_mode = ~vol;
      got = 1'b0;
      waited = 0;
      while (waited < 5000) begin
         @(negedge clk);
         waited++;
         if (poke && waited == 20) start = 1'b1;   // R10 start while busy
         if (poke && waited == 21) start = 1'b0;
         if (done) begin got = 1'b1; break; end
      end
      start = 1'b0;
      chk(got, "R9 done pulse seen", got, 1);
      nb = (busy + 1 < P_LIMIT) ? busy + 1 : P_LIMIT;
      chk(err == (!vol && busy >= P_LIMIT), "R6 err at done", err, (!vol && busy >= P_LIMIT));
      @(negedge clk);
      chk(ready && !done, "R9 ready back after done", {ready, done}, 2);
      chk(n_frames == (vol ? 2 : 3), "R7 frame count", n_frames, vol ? 2 : 3);
      chk(fbits[0] == 8 && fb[0][0] == (vol ? 8'h50 : 8'h06), "R1 enable frame",
          {fbits[0], fb[0][0]}, {8, (vol ? 8'h50 : 8'h06)});
      chk(fbits[1] == 16 && fb[1][0] == exp_opc(idx) && fb[1][1] == data,
          "R2 write frame", {fb[1][0], fb[1][1]}, {exp_opc(idx), data});
      if (!vol) begin
         chk(fbits[2] == 8 * (1 + nb) && fb[2][0] == 8'h05, "R5 poll frame length",
             fbits[2], 8 * (1 + nb));
         fill_ok = 1'b1;
         for (int b = 1; b <= nb; b++) if (fb[2][b] != 8'h00) fill_ok = 1'b0;
         chk(fill_ok, "R5 no opcode while streaming", fill_ok, 1);
         if (busy == P_LIMIT - 1)
            chk(!err && nb == P_LIMIT, "R4 idle wins on last budgeted byte", err, 0);
      end
      chk(gap_bad == 0, "R8 chip select high time", gap_bad, 0);
      chk(sck_bad == 0, "R3 sck half period", sck_bad, 0);
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(spi_cs_n && !spi_sck && !spi_mosi && ready && !done && !err, "R11 reset state",
          {spi_cs_n, spi_sck, spi_mosi, ready, done, err}, 6'b100100);
      rst_n = 1'b1;
      armed = 1'b1;
      repeat (2) @(negedge clk);

      // R10 reg index zero ignored
      clear_log();
      reg_sel = 2'd0; wr_data = 8'h5A; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (40) @(negedge clk);
      chk(ready && n_frames == 0 && spi_cs_n, "R10 index zero ignored", n_frames, 0);

      for (int idx = 1; idx <= 3; idx++) begin
         for (int busy = 0; busy <= P_LIMIT + 2; busy++) begin
            run_op(idx, 8'(8'hA5 ^ (idx * 37 + busy * 11)), 1'b0, busy, busy == 1);
         end
         run_op(idx, 8'(8'h3C + idx * 19), 1'b1, 0, 1'b1);
         run_op(idx, 8'(8'hF0 - idx), 1'b1, 5, 1'b0);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule